// File: doc/BRIEF.md
# Gated Pulse Window Counter

This block counts transitions on a measured input over a window whose ends are the rising edges of a reference input. Both inputs come from outside the clock domain: each is resynchronized and reduced to a one-cycle event inside the block. At the end of each window the running count is copied into a held display register. The counter is cleared one cycle later, so the display always shows the complete total of the window that just closed while the next window is already counting.

Three uses share the same logic. A one-second reference on the reference input gives frequency in pulses per second. A fixed time-base on the measured input, with the unknown signal on the reference input, gives period or cycle time. A programmable divider on the reference stretches the window to 1, 10, 100 or 1000 reference cycles, for ratio readout with extra resolution. The counter saturates, and an overflow flag travels with each held count.

Top module: `gate_counter`

## Requirements
- R1: After reset, heldCount is 0, heldOvf is 0 and updateStrobe is 0.
- R2: With fallEdgeSel = 0, each rising edge of measIn adds one to the window count. heldCount then shows the number of rising edges seen in the window that ended.
- R3: With fallEdgeSel = 1, falling edges of measIn are counted instead of rising edges. A measIn level that rises in one window and falls in the next is counted in the second window.
- R4: A window boundary loads the display. updateStrobe is high for exactly one cycle, in the cycle the new heldCount first appears. That is three clock edges after a refIn rise is presented to the block (two synchronizer stages plus one load register).
- R5: Between boundaries, heldCount and heldOvf keep their values while the next window accumulates.
- R6: The counter is cleared in the cycle after the display load, never in the same cycle. A measIn edge that lands in the load cycle or the clear cycle is counted in the new window, so no edge is lost.
- R7: divSel picks how many refIn rising edges make one window: code 0 = 1, code 1 = 10, code 2 = 100, code 3 = 1000. No update occurs at the intermediate refIn edges.
- R8: The count saturates at 2^CNT_W-1. heldOvf is 1 exactly when more than 2^CNT_W-1 edges arrived in the displayed window, and it returns to 0 for a later window that stays in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| measIn | input | 1 | Measured pulse input (asynchronous) |
| refIn | input | 1 | Reference input whose rising edges end windows (asynchronous) |
| fallEdgeSel | input | 1 | 0 counts rising edges of measIn, 1 counts falling edges |
| divSel | input | 2 | Reference divider: 0 = /1, 1 = /10, 2 = /100, 3 = /1000 |
| heldCount | output | CNT_W (24) | Count of the last complete window |
| heldOvf | output | 1 | Set when the held window saturated |
| updateStrobe | output | 1 | One-cycle pulse when heldCount is reloaded |

## Verification
The bench builds the block with CNT_W = 8. At that width, saturation at 255 and the overflow flag are reached with a few hundred measured pulses, so the exact 255 and 256 boundary can be driven directly. The divider is run at all four settings, including the full thousand-edge window. Edges that coincide with the load cycle and with the clear cycle are placed deliberately, next to random pulse trains with random spacing in both edge modes.

// File: rtl/gate_counter_pkg.sv
package gate_counter_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic countEv;   // one counting event on the measured input
    logic loadDisp;  // copy running count into held display
    logic clearCnt;  // restart running count (cycle after loadDisp)
  } ctrl_strb_t;

  localparam int unsigned MAX_DIV = 1000;

  function automatic int unsigned divFor(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 10;
      2'd2:    return 100;
      default: return MAX_DIV;
    endcase
  endfunction

endpackage

// File: rtl/gate_counter_edge.sv
module gate_counter_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  input  logic selFall,
  output logic ev
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic              syncOut;

  assign syncOut = syncQ[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], din};
      prevQ <= syncOut;
    end
  end

  always_comb begin
    if (selFall) ev = prevQ & ~syncOut;
    else         ev = syncOut & ~prevQ;
  end

endmodule

// File: rtl/gate_counter_ctrl.sv
module gate_counter_ctrl
  import gate_counter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       measEv,
  input  logic       refEv,
  input  logic [1:0] divSel,
  output ctrl_strb_t strb
);

  localparam int PRE_W = $clog2(MAX_DIV);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLast;
  logic             wrap;
  logic             clearPend;

  assign divLast = PRE_W'(divFor(divSel) - 1);
  assign wrap    = refEv && (preCnt >= divLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      clearPend <= 1'b0;
    end else begin
      if (refEv) preCnt <= wrap ? '0 : preCnt + 1'b1;
      clearPend <= wrap;
    end
  end

  always_comb begin
    strb.countEv  = measEv;
    strb.loadDisp = wrap;
    strb.clearCnt = clearPend;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    preCnt < PRE_W'(MAX_DIV)); // R7
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDisp |=> !strb.loadDisp); // R6

endmodule

// File: rtl/gate_counter_dp.sv
module gate_counter_dp
  import gate_counter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  output logic [CNT_W-1:0] heldCount,
  output logic             heldOvf,
  output logic             updateStrobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             carry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt          <= '0;
      ovf          <= 1'b0;
      carry        <= 1'b0;
      heldCount    <= '0;
      heldOvf      <= 1'b0;
      updateStrobe <= 1'b0;
    end else begin
      if (strb.clearCnt) begin
        cnt   <= CNT_W'(strb.countEv) + CNT_W'(carry);
        ovf   <= 1'b0;
        carry <= 1'b0;
      end else if (strb.countEv) begin
        if (strb.loadDisp)      carry <= 1'b1;
        else if (cnt == CNT_MAX) ovf  <= 1'b1;
        else                     cnt  <= cnt + 1'b1;
      end
      if (strb.loadDisp) begin
        heldCount <= cnt;
        heldOvf   <= ovf;
      end
      updateStrobe <= strb.loadDisp;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDisp |=> $stable(heldCount) && $stable(heldOvf)); // R5
  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDisp |=> heldCount == $past(cnt)); // R4
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (cnt <= CNT_W'(2)) && !ovf); // R6
  AST_NO_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadDisp && strb.clearCnt)); // R6
  AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strb.clearCnt) |=> cnt == CNT_MAX); // R8

endmodule

// File: rtl/gate_counter.sv
module gate_counter
  import gate_counter_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             measIn,
  input  logic             refIn,
  input  logic             fallEdgeSel,
  input  logic [1:0]       divSel,
  output logic [CNT_W-1:0] heldCount,
  output logic             heldOvf,
  output logic             updateStrobe
);

  localparam int N_IN = 2;  // index 0: measured, 1: reference

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] selFall;
  logic [N_IN-1:0] evIn;
  ctrl_strb_t      strb;

  assign rawIn   = {refIn, measIn};
  assign selFall = {1'b0, fallEdgeSel};

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    gate_counter_edge #(.STAGES(SYNC_DEPTH)) u_edge (
      .clk     (clk),
      .rstN    (rstN),
      .din     (rawIn[i]),
      .selFall (selFall[i]),
      .ev      (evIn[i])
    );
  end

  gate_counter_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .measEv (evIn[0]),
    .refEv  (evIn[1]),
    .divSel (divSel),
    .strb   (strb)
  );

  gate_counter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .heldCount    (heldCount),
    .heldOvf      (heldOvf),
    .updateStrobe (updateStrobe)
  );

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe); // R4

endmodule

// File: tb/gate_counter_tb.sv
module gate_counter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int MAXV       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             measIn = 1'b0;
  logic             refIn = 1'b0;
  logic             fallEdgeSel = 1'b0;
  logic [1:0]       divSel = 2'd0;
  logic [CNT_W-1:0] heldCount;
  logic             heldOvf;
  logic             updateStrobe;

  int checks = 0;
  int fails  = 0;
  int strobeSeen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_counter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .measIn(measIn), .refIn(refIn),
    .fallEdgeSel(fallEdgeSel), .divSel(divSel),
    .heldCount(heldCount), .heldOvf(heldOvf), .updateStrobe(updateStrobe)
  );

  always @(negedge clk) if (rstN && updateStrobe) strobeSeen++;

  function automatic int expCount(input int n);
    return (n > MAXV) ? MAXV : n;
  endfunction

  function automatic bit expOvf(input int n);
    return n > MAXV;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic fsel, input logic [1:0] dsel);
    rstN = 1'b0; measIn = 1'b0; refIn = 1'b0;
    fallEdgeSel = fsel; divSel = dsel;
    tick(3);
    rstN = 1'b1;
    tick(2);
  endtask

  task automatic pulseA(input int lowGap);
    measIn = 1'b1; tick(2);
    measIn = 1'b0; tick(lowGap);
  endtask

  task automatic pulseB();
    refIn = 1'b1; tick(2);
    refIn = 1'b0; tick(2);
  endtask

  // boundary with full strobe/latency check; aOff: 0 none, 1 A with B, 2 A one cycle after B
  task automatic boundary(input int n, input int aOff, input string req);
    refIn = 1'b1;
    if (aOff == 1) measIn = 1'b1;
    tick(1);
    chk(updateStrobe == 1'b0, "R4", "strobe early 1", updateStrobe, 0);
    if (aOff == 2) measIn = 1'b1;
    tick(1);
    chk(updateStrobe == 1'b0, "R4", "strobe early 2", updateStrobe, 0);
    refIn = 1'b0;
    tick(1);
    chk(updateStrobe == 1'b1, "R4", "strobe at load", updateStrobe, 1);
    chk(heldCount == CNT_W'(expCount(n)), req, "heldCount", heldCount, expCount(n));
    chk(heldOvf == expOvf(n), "R8", "heldOvf", heldOvf, expOvf(n));
    measIn = 1'b0;
    tick(1);
    chk(updateStrobe == 1'b0, "R4", "strobe width", updateStrobe, 0);
    tick(2);
  endtask

  initial begin
    int n, prevN, snap, tot;
    void'($urandom(32'h5eed_1234));
    doReset(1'b0, 2'd0);
    // R1 reset state
    chk(heldCount == 0, "R1", "heldCount", heldCount, 0);
    chk(heldOvf == 0, "R1", "heldOvf", heldOvf, 0);
    chk(updateStrobe == 0, "R1", "updateStrobe", updateStrobe, 0);

    // R2 rising edges, random trains; R5 hold mid-window
    boundary(0, 0, "R2");
    prevN = 0;
    for (int w = 0; w < 10; w++) begin
      n = $urandom_range(0, 300);
      for (int i = 0; i < n; i++) pulseA($urandom_range(2, 4));
      chk(heldCount == CNT_W'(expCount(prevN)), "R5", "hold mid-window", heldCount, expCount(prevN));
      chk(heldOvf == expOvf(prevN), "R5", "ovf hold", heldOvf, expOvf(prevN));
      boundary(n, 0, "R2");
      prevN = n;
    end

    // R8 exact saturation corners
    for (int i = 0; i < MAXV; i++) pulseA(2);
    boundary(MAXV, 0, "R8");
    for (int i = 0; i < MAXV + 1; i++) pulseA(2);
    boundary(MAXV + 1, 0, "R8");
    for (int i = 0; i < 3; i++) pulseA(2);
    boundary(3, 0, "R8");

    // R6 edge in load cycle, then edge in clear cycle
    for (int i = 0; i < 5; i++) pulseA(2);
    boundary(5, 1, "R6");
    for (int i = 0; i < 4; i++) pulseA(2);
    boundary(4 + 1, 2, "R6");
    for (int i = 0; i < 2; i++) pulseA(2);
    boundary(2 + 1, 0, "R6");

    // R3 falling edges
    doReset(1'b1, 2'd0);
    boundary(0, 0, "R3");
    measIn = 1'b1; tick(4);
    refIn = 1'b1; tick(2); refIn = 1'b0; tick(1);
    chk(heldCount == 0, "R3", "rise not counted", heldCount, 0);
    tick(3);
    measIn = 1'b0; tick(4);
    boundary(1, 0, "R3");
    for (int w = 0; w < 3; w++) begin
      n = $urandom_range(1, 60);
      for (int i = 0; i < n; i++) pulseA($urandom_range(2, 5));
      boundary(n, 0, "R3");
    end

    // R7 prescaler /10, /100, /1000
    for (int d = 1; d < 4; d++) begin
      int div;
      div = (d == 1) ? 10 : (d == 2) ? 100 : 1000;
      doReset(1'b0, 2'(d));
      tot = 0;
      snap = strobeSeen;
      for (int b = 0; b < div - 1; b++) begin
        if ((b % (div / 10)) == 0) begin
          n = $urandom_range(0, 3);
          for (int i = 0; i < n; i++) pulseA(2);
          tot += n;
        end
        pulseB();
      end
      chk(strobeSeen == snap, "R7", "no update before last ref edge", strobeSeen - snap, 0);
      boundary(tot, 0, "R7");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule